// File: doc/BRIEF.md
# Boot Header Scanner

After reset this sequencer walks a fixed, ordered list of five flash locations through a synchronous word-read port with a request/valid handshake. At each location it reads the first word and compares it with a marker value. The first location whose marker matches is taken as the boot header. The scanner then reads the boot configuration word and one vector table base address per core. It stops reading at that point.

From the header it derives a per-core enable mask and a per-core vector base for up to four cores. Each vector base is forced down to a 128-byte boundary. A misaligned address on an enabled core raises an error flag.

If none of the five locations holds the marker, the scanner falls back to a default configuration: only core 0 is enabled and every vector base is zero. A one-cycle done pulse marks the moment the results become valid. The results then stay constant until the next reset.

Top module: `boot_hdr_scan`

## Requirements
- R1: Marker reads go to 0x00400000, 0x00600000, 0x00800000, 0x00A00000 and 0x10000000, strictly in that order, and each location is read only after the previous one was rejected.
- R2: A location holds a header only when its first word equals exactly 0x5AA55AA5; any other value, including one differing in a single bit, is rejected.
- R3: Bit n of the configuration word (bits 3..0) enables core n on `core_en[n]`; configuration bits 31..4 have no effect on any output.
- R4: Header words are read at base+0 (marker), base+4 (configuration), and base+8+4*n (vector base of core n, n = 0..3), in ascending address order; every `rd_addr` is word aligned.
- R5: For an enabled core n, `vec_base[32*n+31:32*n]` is the header address with bits 6..0 cleared, and `align_err` is 1 when any enabled core's address had a nonzero bit in 6..0. A disabled core outputs 0 and its address never raises `align_err`.
- R6: When no location holds the marker, `hdr_found` is 0, `core_en` is 4'b0001, every vector base is 0 and `align_err` is 0.
- R7: Scanning stops at the first valid header. No read is requested after completion, and all results hold their values until reset.
- R8: `scan_done` is high for exactly one cycle: the cycle right after the clock edge that accepts the data of the final read.
- R9: At most one read is outstanding. `rd_req` is a one-cycle pulse, and the next request comes only after `rd_valid` returns the data, for any latency of one or more cycles.
- R10: During reset and until `scan_done`, `hdr_found`, `core_en`, `vec_base` and `align_err` are all zero, and `rd_req` is low while reset is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; a scan starts after release |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | 32 | Byte address of the requested word, valid with `rd_req` |
| rd_valid | input | 1 | Read data valid, one or more cycles after `rd_req` |
| rd_data | input | 32 | Read data, sampled with `rd_valid` |
| scan_done | output | 1 | One-cycle pulse when results become valid |
| hdr_found | output | 1 | A valid header was found |
| core_en | output | 4 | Per-core enable mask |
| vec_base | output | 128 | Per-core vector base, core n at bits 32n+31..32n |
| align_err | output | 1 | An enabled core's vector address was not 128-byte aligned |

## Verification
The bench memory model answers each request after a random 1 to 4 cycles. It records the cycle in which it raised `rd_valid` for the final word, and it expects `scan_done` exactly one cycle later. The results are compared in that same cycle, and then again on every cycle of a quiet window during which no request may appear. All ports are sampled on the falling edge. While a response is still pending, the bench checks at each falling edge that `rd_req` stays low.

// File: rtl/boot_scan_pkg.sv
package boot_scan_pkg;

    localparam int unsigned SCAN_SLOTS = 5;
    localparam logic [31:0] HDR_MAGIC  = 32'h5AA5_5AA5;

    typedef enum logic [1:0] {
        SC_START,
        SC_ISSUE,
        SC_WAIT,
        SC_FIN
    } scan_st_e;

    // Probe order is behaviour: earlier slots win.
    function automatic logic [31:0] slot_base(input logic [2:0] idx);
        case (idx)
            3'd0:    return 32'h0040_0000;
            3'd1:    return 32'h0060_0000;
            3'd2:    return 32'h0080_0000;
            3'd3:    return 32'h00A0_0000;
            3'd4:    return 32'h1000_0000;
            default: return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/boot_scan_addr.sv
module boot_scan_addr #(
    parameter int unsigned SLOT_W = 3,
    parameter int unsigned WIDX_W = 3,
    parameter int unsigned WORD_W = 32
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [WIDX_W-1:0] widx,
    output logic [WORD_W-1:0] addr
);
    import boot_scan_pkg::*;

    logic [2:0]        slot_ext;
    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] offs;

    always_comb begin
        slot_ext = 3'(slot);
        base     = WORD_W'(slot_base(slot_ext));
        offs     = WORD_W'(widx) << 2;
        addr     = base + offs;
    end

endmodule

// File: rtl/boot_scan_align.sv
module boot_scan_align #(
    parameter int unsigned NUM_CORES  = 4,
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned ALIGN_BITS = 7
) (
    input  logic [NUM_CORES*WORD_W-1:0] raw_vec,
    output logic [NUM_CORES*WORD_W-1:0] aligned_vec,
    output logic [NUM_CORES-1:0]        misaligned
);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic [WORD_W-1:0] word;
        assign word = raw_vec[c*WORD_W +: WORD_W];
        assign aligned_vec[c*WORD_W +: WORD_W] =
            {word[WORD_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        assign misaligned[c] = |word[ALIGN_BITS-1:0];
    end

endmodule

// File: rtl/boot_hdr_scan.sv
module boot_hdr_scan #(
    parameter int unsigned          NUM_CORES   = 4,
    parameter int unsigned          WORD_W      = 32,
    parameter int unsigned          ALIGN_BITS  = 7,
    parameter logic [NUM_CORES-1:0] FALLBACK_EN = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    output logic                        rd_req,
    output logic [WORD_W-1:0]           rd_addr,
    input  logic                        rd_valid,
    input  logic [WORD_W-1:0]           rd_data,
    output logic                        scan_done,
    output logic                        hdr_found,
    output logic [NUM_CORES-1:0]        core_en,
    output logic [NUM_CORES*WORD_W-1:0] vec_base,
    output logic                        align_err
);
    import boot_scan_pkg::*;

    localparam int unsigned HDR_WORDS = NUM_CORES + 2;
    localparam int unsigned WIDX_W    = $clog2(HDR_WORDS);
    localparam int unsigned SLOT_W    = $clog2(SCAN_SLOTS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SCAN_SLOTS - 1);
    localparam logic [WIDX_W-1:0] W_MARK    = '0;
    localparam logic [WIDX_W-1:0] W_CFG     = WIDX_W'(1);
    localparam logic [WIDX_W-1:0] W_VEC0    = WIDX_W'(2);
    localparam logic [WIDX_W-1:0] W_LAST    = WIDX_W'(HDR_WORDS - 1);

    typedef struct packed {
        scan_st_e                    st;
        logic [SLOT_W-1:0]           slot;
        logic [WIDX_W-1:0]           widx;
        logic [NUM_CORES-1:0]        cfg;
        logic [NUM_CORES*WORD_W-1:0] raw;
        logic                        found;
        logic                        done;
    } scan_regs_t;

    scan_regs_t r_d, r_q;

    logic [NUM_CORES*WORD_W-1:0] aligned_vec;
    logic [NUM_CORES-1:0]        misaligned;
    logic                        fin;

    // Next-state logic
    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            SC_START: r_d.st = SC_ISSUE;
            SC_ISSUE: r_d.st = SC_WAIT;
            SC_WAIT: begin
                if (rd_valid) begin
                    if (r_q.widx == W_MARK) begin
                        if (rd_data == WORD_W'(HDR_MAGIC)) begin
                            r_d.widx = W_CFG;
                            r_d.st   = SC_ISSUE;
                        end else if (r_q.slot == LAST_SLOT) begin
                            r_d.found = 1'b0;
                            r_d.done  = 1'b1;
                            r_d.st    = SC_FIN;
                        end else begin
                            r_d.slot = r_q.slot + SLOT_W'(1);
                            r_d.st   = SC_ISSUE;
                        end
                    end else if (r_q.widx == W_CFG) begin
                        r_d.cfg  = rd_data[NUM_CORES-1:0];
                        r_d.widx = W_VEC0;
                        r_d.st   = SC_ISSUE;
                    end else begin
                        for (int c = 0; c < NUM_CORES; c++) begin
                            if (int'(r_q.widx) == c + 2) begin
                                r_d.raw[c*WORD_W +: WORD_W] = rd_data;
                            end
                        end
                        if (r_q.widx == W_LAST) begin
                            r_d.found = 1'b1;
                            r_d.done  = 1'b1;
                            r_d.st    = SC_FIN;
                        end else begin
                            r_d.widx = r_q.widx + WIDX_W'(1);
                            r_d.st   = SC_ISSUE;
                        end
                    end
                end
            end
            SC_FIN:  r_d.st = SC_FIN;
            default: r_d.st = SC_START;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= SC_START;
        end else begin
            r_q <= r_d;
        end
    end

    boot_scan_addr #(
        .SLOT_W (SLOT_W),
        .WIDX_W (WIDX_W),
        .WORD_W (WORD_W)
    ) i_addr (
        .slot (r_q.slot),
        .widx (r_q.widx),
        .addr (rd_addr)
    );

    boot_scan_align #(
        .NUM_CORES  (NUM_CORES),
        .WORD_W     (WORD_W),
        .ALIGN_BITS (ALIGN_BITS)
    ) i_align (
        .raw_vec     (r_q.raw),
        .aligned_vec (aligned_vec),
        .misaligned  (misaligned)
    );

    // Outputs
    assign fin       = (r_q.st == SC_FIN);
    assign rd_req    = (r_q.st == SC_ISSUE);
    assign scan_done = r_q.done;
    assign hdr_found = fin && r_q.found;
    assign core_en   = !fin ? '0 : (r_q.found ? r_q.cfg : FALLBACK_EN);
    assign align_err = hdr_found && |(r_q.cfg & misaligned);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_vec
        assign vec_base[c*WORD_W +: WORD_W] =
            (hdr_found && r_q.cfg[c]) ? aligned_vec[c*WORD_W +: WORD_W] : '0;
    end

    // Checks
    p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    p_req_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr[1:0] == 2'b00));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);

    p_quiet_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> !rd_req);

    p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && $past(fin)) |-> ($stable(core_en) && $stable(vec_base)
                                 && $stable(align_err) && $stable(hdr_found)));

    p_err_needs_hdr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> hdr_found);

    p_done_sets_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_done) |-> (core_en != '0 || r_q.cfg == '0));

endmodule

// File: tb/test_boot_hdr_scan.sv
`timescale 1ns/1ps
module test_boot_hdr_scan;

    localparam logic [31:0] MAGIC = 32'h5AA5_5AA5;

    logic         clk;
    logic         rst_n;
    logic         rd_req;
    logic [31:0]  rd_addr;
    logic         rd_valid;
    logic [31:0]  rd_data;
    logic         scan_done;
    logic         hdr_found;
    logic [3:0]   core_en;
    logic [127:0] vec_base;
    logic         align_err;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int last_valid_cyc = 0;
    int req_n = 0;
    logic [31:0] req_log [64];
    logic [31:0] img [5][6];

    boot_hdr_scan i_boot_hdr_scan (
        .clk (clk), .rst_n (rst_n),
        .rd_req (rd_req), .rd_addr (rd_addr),
        .rd_valid (rd_valid), .rd_data (rd_data),
        .scan_done (scan_done), .hdr_found (hdr_found),
        .core_en (core_en), .vec_base (vec_base), .align_err (align_err)
    );

    initial begin
        clk = 1'b0;
        forever #2.5 clk = ~clk;
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc = cyc + 1;
        end
    end

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] tb_base(input int b);
        case (b)
            0: return 32'h0040_0000;
            1: return 32'h0060_0000;
            2: return 32'h0080_0000;
            3: return 32'h00A0_0000;
            default: return 32'h1000_0000;
        endcase
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        for (int b = 0; b < 5; b++)
            for (int w = 0; w < 6; w++)
                if (a == tb_base(b) + 32'(4 * w)) return img[b][w];
        return 32'hDEAD_0000 ^ a;
    endfunction

    function automatic int exp_slot();
        for (int b = 0; b < 5; b++)
            if (img[b][0] == MAGIC) return b;
        return 5;
    endfunction

    // Memory responder with random latency 1..4
    initial begin
        rd_valid = 1'b0;
        rd_data  = '0;
        forever begin
            @(negedge clk);
            rd_valid = 1'b0;
            if (rst_n && rd_req) begin
                logic [31:0] a;
                int lat;
                a = rd_addr;
                if (req_n < 64) req_log[req_n] = a;
                req_n++;
                lat = $urandom_range(1, 4);
                for (int k = 0; k < lat; k++) begin
                    @(negedge clk);
                    chk(!rd_req, "R9 no request while pending", 128'(rd_req), 128'(0));
                end
                rd_valid = 1'b1;
                rd_data  = mem_word(a);
                last_valid_cyc = cyc;
            end
        end
    end

    task automatic fill_junk();
        for (int b = 0; b < 5; b++)
            for (int w = 0; w < 6; w++) begin
                logic [31:0] v;
                v = $urandom;
                if (v == MAGIC) v = v ^ 32'h1;
                img[b][w] = v;
            end
    endtask

    task automatic run_case(input string name);
        int s;
        bit found_e;
        logic [3:0] en_e;
        logic [127:0] vec_e;
        bit err_e;
        int nreq_e;
        bit got;
        logic [3:0] en_hold;
        logic [127:0] vec_hold;

        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!rd_req && !scan_done && !hdr_found && core_en == 0 && vec_base == 0 && !align_err,
            {"R10 reset state ", name}, {rd_req, scan_done, hdr_found, core_en, align_err}, 0);
        req_n = 0;
        rst_n = 1'b1;

        got = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (scan_done) begin got = 1'b1; break; end
            if (i == 3)
                chk(!hdr_found && core_en == 0 && vec_base == 0 && !align_err,
                    {"R10 idle before done ", name}, {hdr_found, core_en, align_err}, 0);
        end
        chk(got, {"R8 done seen ", name}, 128'(got), 128'(1));
        chk(cyc == last_valid_cyc + 1, {"R8 done timing ", name},
            128'(cyc), 128'(last_valid_cyc + 1));

        s       = exp_slot();
        found_e = (s < 5);
        en_e    = found_e ? img[s][1][3:0] : 4'b0001;
        vec_e   = '0;
        err_e   = 1'b0;
        if (found_e)
            for (int c = 0; c < 4; c++)
                if (en_e[c]) begin
                    vec_e[32*c +: 32] = img[s][2+c] & 32'hFFFF_FF80;
                    if (img[s][2+c][6:0] != 7'd0) err_e = 1'b1;
                end

        chk(hdr_found == found_e, {"R2 found flag ", name}, 128'(hdr_found), 128'(found_e));
        chk(core_en == en_e, {found_e ? "R3 enables " : "R6 fallback enables ", name},
            128'(core_en), 128'(en_e));
        chk(vec_base == vec_e, {found_e ? "R5 vectors " : "R6 fallback vectors ", name},
            vec_base, vec_e);
        chk(align_err == err_e, {"R5 align error ", name}, 128'(align_err), 128'(err_e));

        // Request sequence: marker reads in order, then header words
        nreq_e = found_e ? s + 6 : 5;
        chk(req_n == nreq_e, {"R1 read count ", name}, 128'(req_n), 128'(nreq_e));
        for (int k = 0; k < nreq_e && k < req_n; k++) begin
            logic [31:0] ea;
            if (k < s || !found_e) ea = tb_base(k);
            else ea = tb_base(s) + 32'(4 * (k - s));
            chk(req_log[k] == ea, {(k < s || !found_e) ? "R1 probe address " : "R4 header address ", name},
                128'(req_log[k]), 128'(ea));
        end

        @(negedge clk);
        chk(!scan_done, {"R8 done one cycle ", name}, 128'(scan_done), 128'(0));
        en_hold  = core_en;
        vec_hold = vec_base;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(!rd_req && core_en == en_hold && vec_base == vec_hold && !scan_done,
                {"R7 quiet and held ", name}, {rd_req, scan_done, core_en}, {3'b000, en_hold});
        end
    endtask

    initial begin
        int seed_sink;
        rst_n = 1'b0;
        seed_sink = $urandom(32'h00C0_FFEE);

        // No header anywhere
        fill_junk();
        run_case("none");

        // Header in first slot, all cores, aligned
        fill_junk();
        img[0][0] = MAGIC; img[0][1] = 32'h0000_000F;
        for (int c = 0; c < 4; c++) img[0][2+c] = 32'h0040_1000 + 32'(c * 32'h200);
        run_case("slot0 all");

        // Slot 3 wins over slot 4; core 2 misaligned; disabled core 1 misaligned
        fill_junk();
        img[3][0] = MAGIC; img[3][1] = 32'h0000_0005;
        img[3][2] = 32'h00A0_0400; img[3][3] = 32'h1234_5677;
        img[3][4] = 32'h00A0_0845; img[3][5] = 32'h0000_0000;
        img[4][0] = MAGIC; img[4][1] = 32'h0000_000F;
        run_case("slot3 mixed");

        // Only DFLASH slot, upper config bits set
        fill_junk();
        img[4][0] = MAGIC; img[4][1] = 32'hFFF0_0002;
        img[4][3] = 32'h1000_0080;
        run_case("slot4 upper cfg");

        // Near-miss marker in slot 1, real one in slot 2
        fill_junk();
        img[1][0] = 32'h5AA5_5AA4; img[1][1] = 32'h0000_000F;
        img[2][0] = MAGIC; img[2][1] = 32'h0000_0008;
        img[2][5] = 32'h0080_0F81;
        run_case("near miss");

        // Header present with no core enabled
        fill_junk();
        img[0][0] = MAGIC; img[0][1] = 32'h0000_0000;
        run_case("zero cfg");

        for (int t = 0; t < 24; t++) begin
            fill_junk();
            for (int b = 0; b < 5; b++)
                if ($urandom_range(0, 99) < 25) img[b][0] = MAGIC;
            for (int b = 0; b < 5; b++)
                for (int c = 0; c < 4; c++)
                    if ($urandom_range(0, 1) == 1) img[b][2+c] = img[b][2+c] & 32'hFFFF_FF80;
            run_case("random");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

endmodule